// File: doc/BRIEF.md
# Float to Saturating Fixed-Point Converter

This block converts one IEEE-754 single-precision operand per cycle into a 32-bit integer. Before conversion the operand is scaled by 2^k, where k is a 5-bit unsigned scale. The scaling is done by adding k to the exponent, so it costs no multiplier. The result is truncated toward zero. A mode bit selects a signed (two's complement) or an unsigned result.

Any result that cannot be represented is clamped to the nearest limit of the selected range. Each clamp raises a sticky saturation flag. The flag stays set until a clear pulse or reset. A NaN operand converts to zero and does not touch the flag.

The output stage is a two-state machine:
- In OUT_IDLE, no result is presented.
- In OUT_BUSY, the registered result is presented with out_valid high.

Its transitions are:
- WAIT: OUT_IDLE to OUT_IDLE, with no input strobe.
- ACCEPT: OUT_IDLE to OUT_BUSY, on an input strobe.
- STREAM: OUT_BUSY to OUT_BUSY, on back-to-back strobes.
- DRAIN: OUT_BUSY to OUT_IDLE, when the strobe drops.

Top module: `f2i_conv`

## Requirements
- R1: out_valid is high exactly one cycle after in_valid is high (state OUT_BUSY). out_data takes the converted value on that same edge and holds it while in_valid is low.
- R2: A NaN operand (exponent field bits 30:23 all ones, fraction bits 22:0 nonzero) converts to 0 and does not set sat_flag.
- R3: The effective exponent is the exponent field minus 127 plus in_scale. When it is negative the result is 0 and sat_flag is not set, in both modes; this covers ±0 and denormals.
- R4: Signed mode (in_signed=1), effective exponent 0 to 30: the result is the magnitude floor(|x|·2^scale), negated when bit 31 of the operand is set.
- R5: Signed mode, effective exponent 31 or more, non-NaN: the result is 0x7FFFFFFF for a positive operand and 0x80000000 for a negative one, and sat_flag is set.
- R6: Signed mode: when the operand plus (scale shifted left by 23) equals 0xCF000000 (exactly -2^31), the result is 0x80000000 and sat_flag is not set.
- R7: Unsigned mode (in_signed=0), positive operand, effective exponent 0 to 31: the result is floor(x·2^scale).
- R8: Unsigned mode, negative operand with effective exponent 0 or more: the result is 0 and sat_flag is set.
- R9: Unsigned mode, positive operand with effective exponent 32 or more (including +Inf): the result is 0xFFFFFFFF and sat_flag is set.
- R10: sat_flag is sticky. It is cleared by sat_clr one cycle later. A saturating conversion in the same cycle as sat_clr leaves the flag set.
- R11: During and right after reset, out_valid, out_data and sat_flag are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_float | input | 32 | Single-precision operand |
| in_scale | input | 5 | Unsigned scale exponent k |
| in_signed | input | 1 | 1 = signed result, 0 = unsigned |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result strobe |
| out_data | output | 32 | Converted integer |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The converted value, out_valid and the updated saturation flag all appear after exactly one rising edge following the cycle in which the operand was strobed. The bench drives each operand on a falling edge and compares all three outputs on the next falling edge, which lies half a cycle after the single register stage. Clear pulses are checked the same way, one edge after they are applied. The idle cycles that follow are used to confirm that out_valid drops and that out_data holds its last value.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
    localparam int WORD_W   = 32;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int EXP_BIAS = 127;
    localparam int EFF_W    = 10;
    localparam int SHAMT_W  = 5;
    localparam int SINT_TOP = WORD_W - 1;   // first signed overflow exponent
    localparam int UINT_TOP = WORD_W;       // first unsigned overflow exponent
    localparam int MIN_EXP  = EXP_BIAS + WORD_W - 1; // biased exponent of 2^31

    typedef enum logic [2:0] {
        CLS_NAN,
        CLS_UNDER,
        CLS_NEGU,
        CLS_OVF,
        CLS_RANGE
    } cls_e;

    typedef enum logic {
        OUT_IDLE,
        OUT_BUSY
    } ostate_e;

    typedef struct packed {
        logic                    sign;
        logic                    is_nan;
        logic                    min_exact;
        logic signed [EFF_W-1:0] eff;
        logic [SIG_W-1:0]        sig;
    } dec_t;
endpackage

// File: rtl/f2i_decode.sv
module f2i_decode
    import f2i_pkg::*;
#(
    parameter int SCALE_W = 5
) (
    input  logic [WORD_W-1:0]  fp,
    input  logic [SCALE_W-1:0] scale,
    output dec_t               dec
);
    localparam logic signed [EFF_W-1:0] BIAS_S  = EFF_W'(EXP_BIAS);
    localparam logic [EFF_W-1:0]        MIN_SUM = EFF_W'(MIN_EXP);

    logic [EXP_W-1:0]  e_fld;
    logic [FRAC_W-1:0] f_fld;
    logic [EFF_W-1:0]  e_plus_k;

    assign e_fld    = fp[WORD_W-2 -: EXP_W];
    assign f_fld    = fp[FRAC_W-1:0];
    assign e_plus_k = EFF_W'(e_fld) + EFF_W'(scale);

    always_comb begin
        dec.sign      = fp[WORD_W-1];
        dec.is_nan    = (e_fld == '1) && (f_fld != '0);
        dec.eff       = $signed(e_plus_k) - BIAS_S;
        dec.sig       = {1'b1, f_fld};
        // scaled operand is exactly -2^31
        dec.min_exact = fp[WORD_W-1] && (f_fld == '0) && (e_plus_k == MIN_SUM);
    end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
#(
    parameter bit SIGNED_VAR = 1'b1
) (
    input  logic [SIG_W-1:0]   sig,
    input  logic [SHAMT_W-1:0] pos,
    output logic [WORD_W-1:0]  mag
);
    generate
        if (SIGNED_VAR) begin : g_sgn
            localparam int PAD = WORD_W - 1 - SIG_W;
            logic [WORD_W-2:0]  wide;
            logic [SHAMT_W-1:0] rsh;
            assign wide = {sig, {PAD{1'b0}}};
            assign rsh  = SHAMT_W'(WORD_W - 2) - pos;
            assign mag  = {1'b0, wide >> rsh};
        end else begin : g_uns
            localparam int PAD = WORD_W - SIG_W;
            logic [WORD_W-1:0]  wide;
            logic [SHAMT_W-1:0] rsh;
            assign wide = {sig, {PAD{1'b0}}};
            assign rsh  = SHAMT_W'(WORD_W - 1) - pos;
            assign mag  = wide >> rsh;
        end
    endgenerate
endmodule

// File: rtl/f2i_select.sv
module f2i_select
    import f2i_pkg::*;
(
    input  dec_t              dec,
    input  logic              is_signed,
    input  logic [WORD_W-1:0] mag_s,
    input  logic [WORD_W-1:0] mag_u,
    output logic [WORD_W-1:0] result,
    output logic              sat_now
);
    localparam logic signed [EFF_W-1:0] S_TOP = EFF_W'(SINT_TOP);
    localparam logic signed [EFF_W-1:0] U_TOP = EFF_W'(UINT_TOP);
    localparam logic [WORD_W-1:0] S_MAX = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] S_MIN = {1'b1, {(WORD_W-1){1'b0}}};

    cls_e cls;

    always_comb begin
        if (dec.is_nan)                      cls = CLS_NAN;
        else if (dec.eff < 0)                cls = CLS_UNDER;
        else if (!is_signed && dec.sign)     cls = CLS_NEGU;
        else if (dec.eff >= (is_signed ? S_TOP : U_TOP)) cls = CLS_OVF;
        else                                 cls = CLS_RANGE;
    end

    always_comb begin
        result  = '0;
        sat_now = 1'b0;
        unique case (cls)
            CLS_NAN, CLS_UNDER: begin
                result  = '0;
                sat_now = 1'b0;
            end
            CLS_NEGU: begin
                result  = '0;
                sat_now = 1'b1;
            end
            CLS_OVF: begin
                if (is_signed) begin
                    result  = dec.sign ? S_MIN : S_MAX;
                    sat_now = !dec.min_exact;
                end else begin
                    result  = '1;
                    sat_now = 1'b1;
                end
            end
            CLS_RANGE: begin
                result  = is_signed ? (dec.sign ? -mag_s : mag_s) : mag_u;
                sat_now = 1'b0;
            end
            default: begin
                result  = '0;
                sat_now = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
    import f2i_pkg::*;
#(
    parameter int SCALE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_float,
    input  logic [SCALE_W-1:0] in_scale,
    input  logic               in_signed,
    input  logic               sat_clr,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_data,
    output logic               sat_flag
);
    dec_t              dec;
    logic [WORD_W-1:0] mag_s, mag_u, result;
    logic              sat_now;
    ostate_e           st_q, st_d;
    logic [WORD_W-1:0] data_q;
    logic              sat_q;

    f2i_decode #(.SCALE_W(SCALE_W)) u_dec (
        .fp(in_float), .scale(in_scale), .dec(dec)
    );

    f2i_align #(.SIGNED_VAR(1'b1)) u_al_s (
        .sig(dec.sig), .pos(dec.eff[SHAMT_W-1:0]), .mag(mag_s)
    );

    f2i_align #(.SIGNED_VAR(1'b0)) u_al_u (
        .sig(dec.sig), .pos(dec.eff[SHAMT_W-1:0]), .mag(mag_u)
    );

    f2i_select u_sel (
        .dec(dec), .is_signed(in_signed), .mag_s(mag_s), .mag_u(mag_u),
        .result(result), .sat_now(sat_now)
    );

    // next-state: WAIT, ACCEPT, STREAM, DRAIN
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OUT_IDLE: st_d = in_valid ? OUT_BUSY : OUT_IDLE;
            OUT_BUSY: st_d = in_valid ? OUT_BUSY : OUT_IDLE;
            default:  st_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OUT_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            sat_q  <= 1'b0;
        end else begin
            if (in_valid) data_q <= result;
            sat_q <= (sat_q & ~sat_clr) | (in_valid & sat_now);
        end
    end

    always_comb begin
        out_valid = (st_q == OUT_BUSY);
        out_data  = data_q;
        sat_flag  = sat_q;
    end

    // R1
    valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));
    // R2
    nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_float[30:23] == 8'hFF && in_float[22:0] != '0)
        |=> (out_data == '0));
    // R2
    nan_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sat_flag && !sat_clr && in_float[30:23] == 8'hFF &&
         in_float[22:0] != '0) |=> !sat_flag);
    // R5
    pos_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_signed && !in_float[31] &&
         !(in_float[30:23] == 8'hFF && in_float[22:0] != '0) &&
         (9'(in_float[30:23]) + 9'(in_scale) >= 9'd158))
        |=> (out_data == 32'h7FFF_FFFF && sat_flag));
    // R10
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clr) |=> sat_flag);
    // R10
    sat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clr && !in_valid) |=> !sat_flag);
endmodule

// File: tb/tb_f2i_conv.sv
module tb_f2i_conv;
    logic        clk = 1'b0;
    logic        rst_n, in_valid, in_signed, sat_clr;
    logic [31:0] in_float;
    logic [4:0]  in_scale;
    logic        out_valid, sat_flag;
    logic [31:0] out_data;
    int          n_cmp = 0, n_bad = 0;
    logic        model_sat = 1'b0;
    logic [31:0] last_data = '0;

    always #4 clk = ~clk;

    f2i_conv dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_float(in_float),
        .in_scale(in_scale), .in_signed(in_signed), .sat_clr(sat_clr),
        .out_valid(out_valid), .out_data(out_data), .sat_flag(sat_flag)
    );

    function automatic logic [32:0] ref_conv(input logic [31:0] x, input int sc, input logic sgn);
        int          e, eff;
        logic [22:0] f;
        logic [31:0] sum;
        longint      m;
        e = int'(x[30:23]); f = x[22:0]; eff = e - 127 + sc;
        sum = x + (32'(sc) << 23);
        if (e == 255 && f != 0) return 33'd0;
        if (eff < 0) return 33'd0;
        m = (longint'({1'b1, f}) << eff) >> 23;
        if (sgn) begin
            if (eff >= 31)
                return {sum != 32'hCF00_0000, x[31] ? 32'h8000_0000 : 32'h7FFF_FFFF};
            return {1'b0, x[31] ? -m[31:0] : m[31:0]};
        end
        if (x[31]) return {1'b1, 32'd0};
        if (eff >= 32) return {1'b1, 32'hFFFF_FFFF};
        return {1'b0, m[31:0]};
    endfunction

    function automatic string tag_of(input logic [31:0] x, input int sc, input logic sgn);
        int eff;
        eff = int'(x[30:23]) - 127 + sc;
        if (x[30:23] == 8'hFF && x[22:0] != 0) return "R2";
        if (eff < 0) return "R3";
        if (sgn) begin
            if (eff >= 31) return ((x + (32'(sc) << 23)) == 32'hCF00_0000) ? "R6" : "R5";
            return "R4";
        end
        if (x[31]) return "R8";
        return (eff >= 32) ? "R9" : "R7";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic convert(input logic [31:0] x, input int sc, input logic sgn, input logic clr);
        logic [32:0] exp;
        string       tg;
        @(negedge clk);
        in_float = x; in_scale = 5'(sc); in_signed = sgn; sat_clr = clr; in_valid = 1'b1;
        exp = ref_conv(x, sc, sgn);
        tg = tag_of(x, sc, sgn);
        model_sat = (clr ? 1'b0 : model_sat) | exp[32];
        @(negedge clk);
        in_valid = 1'b0; sat_clr = 1'b0;
        check(tg, out_data, exp[31:0]);
        check({tg, " flag R10"}, {31'd0, sat_flag}, {31'd0, model_sat});
        check("R1 valid", {31'd0, out_valid}, 32'd1);
        last_data = exp[31:0];
    endtask

    task automatic idle_and_clear();
        @(negedge clk);
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        model_sat = 1'b0;
        check("R10 clear", {31'd0, sat_flag}, 32'd0);
        check("R1 drop", {31'd0, out_valid}, 32'd0);
        check("R1 hold", out_data, last_data);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_float = '0; in_scale = '0;
        in_signed = 1'b0; sat_clr = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 valid", {31'd0, out_valid}, 32'd0);
        check("R11 data", out_data, 32'd0);
        check("R11 flag", {31'd0, sat_flag}, 32'd0);
        rst_n = 1'b1;

        // R6 exact -2^31, directly and via scale
        convert(32'hCF00_0000, 0, 1'b1, 1'b0);
        convert(32'hCE80_0000, 1, 1'b1, 1'b0);
        // R3 zeros and denormals
        convert(32'h0000_0000, 31, 1'b1, 1'b0);
        convert(32'h8000_0000, 31, 1'b0, 1'b0);
        convert(32'h0000_0001, 31, 1'b0, 1'b0);
        convert(32'h807F_FFFF, 31, 1'b1, 1'b0);
        // R2 NaN
        convert(32'h7FC0_0001, 5, 1'b1, 1'b0);
        convert(32'hFF80_0001, 0, 1'b0, 1'b0);
        // R7 largest below 2^32
        convert(32'h4F7F_FFFF, 0, 1'b0, 1'b0);
        // R5 +2^31, -Inf, +Inf
        convert(32'h4F00_0000, 0, 1'b1, 1'b0);
        idle_and_clear();
        convert(32'hFF80_0000, 0, 1'b1, 1'b0);
        idle_and_clear();
        convert(32'h7F80_0000, 0, 1'b1, 1'b0);
        idle_and_clear();
        // R9 2^32 and +Inf unsigned
        convert(32'h4F80_0000, 0, 1'b0, 1'b0);
        convert(32'h7F80_0000, 3, 1'b0, 1'b0);
        idle_and_clear();
        // R8 negative unsigned
        convert(32'hBF80_0000, 0, 1'b0, 1'b0);
        // R10 set wins over a simultaneous clear
        convert(32'h7F80_0000, 0, 1'b0, 1'b1);
        idle_and_clear();

        // all scale values, R4 and R7 sweeps
        for (int sc = 0; sc < 32; sc++) begin
            convert(32'h3FC0_0000, sc, 1'b1, 1'b0);
            convert(32'hBFC0_0000, sc, 1'b1, 1'b0);
            convert(32'h3FC0_0000, sc, 1'b0, 1'b0);
            idle_and_clear();
        end

        for (int i = 0; i < 800; i++) begin
            logic [31:0] x;
            x[31]    = 1'($urandom);
            x[30:23] = 8'(100 + ($urandom % 75));
            x[22:0]  = 23'($urandom);
            if (($urandom % 40) == 0) x[30:23] = 8'hFF;
            convert(x, int'($urandom % 32), 1'($urandom), (($urandom % 16) == 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule